// File: doc/BRIEF.md
# GPIO Port with Pull-up and Edge Interrupt

This block is one eight-pin general-purpose I/O port that sits on a simple register bus. Software controls it through two registers. The output register holds one bit per pin and can be read back. The pull control register holds one active-low bit per pin and cannot be read. Together, the two bits of a pin choose how the pad behaves: it sinks current (the pin is driven low), it is pulled up through a resistor, or it floats in high impedance. The pad electronics live outside the block; the block drives only the two enables for each pin.

The pull control bit has a second job. It also picks the edge that raises that pin's interrupt. When the bit is clear, a falling edge raises the interrupt. When the bit is set, a rising edge raises it. Pin levels enter through a synchronizer. A read of the output register's address returns these synchronized pin levels, not the stored bits, so software always sees what is on the wire. Each interrupt request is a single-cycle pulse per pin.

The reset input is asynchronous and active low. Its release is synchronized inside the block, so the block leaves reset two clock edges after the input is released.

Top module: `gpio_pull_port`

## Requirements
- R1: After reset, every output register bit is 1 and every pull control bit is 0. So `drive_low_o` is 0x00, `pullup_o` is 0xFF and `irq_o` is 0x00.
- R2: A write with `bus_wr`=1 at address 0x00 loads the output register on that clock edge. From then on, `drive_low_o[i]` is the inverse of output bit i.
- R3: `pullup_o[i]` is 1 exactly when output bit i is 1 and pull control bit i is 0. An output bit of 0 forces `pullup_o[i]` to 0 whatever the pull control bit says.
- R4: When output bit i and pull control bit i are both 1, the pin floats: `drive_low_o[i]` and `pullup_o[i]` are both 0.
- R5: A write at address 0x08 loads the pull control register. That register is write-only: reading address 0x08 returns 0x00.
- R6: With `bus_addr`=0x00, `bus_rdata` gives the level of `pin_in` after a two-flop synchronizer. A pin change applied before clock edge k shows on `bus_rdata` after edge k+1.
- R7: With pull control bit i at 0, a high-to-low change on `pin_in[i]` makes `irq_o[i]` 1 for exactly one cycle, after the third clock edge from the change. With the bit at 1, a low-to-high change does the same.
- R8: Writes to any address other than 0x00 and 0x08 are ignored, and so is any cycle with `bus_wr`=0. Reads at such addresses return 0x00.
- R9: No `irq_o` pulse occurs for an edge of the polarity that was not selected, or while the pins are steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside the block |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe; a write takes effect on the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data: synchronized pin levels at 0x00, zero elsewhere |
| pin_in | input | 8 | Sampled pad levels |
| drive_low_o | output | 8 | Per-pin enable for the current sink (drive low) |
| pullup_o | output | 8 | Per-pin enable for the pull-up resistor |
| irq_o | output | 8 | Per-pin single-cycle interrupt pulse |

## Verification
The bench sweeps all 256 output-register values against several pull patterns, and all 256 pull patterns against a fixed output value. A design that decoded the per-pin truth table wrongly would enable the pull-up on a pin that is driven low, or would drive a floating pin. The bench checks read-back in the cycle after the pin change and again one cycle later. A design that returned the stored output bits, or that had the wrong synchronizer depth, would show the wrong value in one of those two cycles. For each pin and each polarity, the bench makes single edges and checks that exactly one pulse appears, in exactly the third cycle. Polarity swapped per bit, pulses that last too long, or edges detected on the raw input would each show up there. Writes to nearby addresses and strobe-low cycles test that the decoder does not alias.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  typedef enum logic [1:0] {
    PAD_SINK   = 2'd0,
    PAD_PULLUP = 2'd1,
    PAD_FLOAT  = 2'd2
  } pad_mode_e;

  // Output bit and active-low pull bit select the pad behaviour.
  function automatic pad_mode_e pad_mode(input logic out_bit, input logic pull_bit);
    if (!out_bit)      return PAD_SINK;
    else if (!pull_bit) return PAD_PULLUP;
    else               return PAD_FLOAT;
  endfunction

  // Pull bit 0 selects a falling edge, 1 selects a rising edge.
  function automatic logic edge_hit(input logic pol_rise, input logic now_lvl,
                                    input logic old_lvl);
    return pol_rise ? (now_lvl & ~old_lvl) : (~now_lvl & old_lvl);
  endfunction

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= 2'b00;
    else        chain_q <= {chain_q[0], 1'b1};
  end

  assign rst_sync_n = chain_q[1];
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '1;
        else        stage_q[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '1;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int                WIDTH     = 8,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h00,
  parameter logic [ADDR_W-1:0] PULL_ADDR = 8'h08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  out_q,
  output logic [WIDTH-1:0]  pull_q
);
  logic             out_en, pull_en;
  logic [WIDTH-1:0] out_d, pull_d;

  always_comb begin
    out_en  = bus_wr && (bus_addr == DATA_ADDR);
    pull_en = bus_wr && (bus_addr == PULL_ADDR);
    out_d   = bus_wdata;
    pull_d  = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_q <= '1;
    else if (out_en) out_q <= out_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pull_q <= '0;
    else if (pull_en) pull_q <= pull_d;
  end
endmodule

// File: rtl/gpio_edge.sv
module gpio_edge #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level,
  input  logic [WIDTH-1:0] pol_rise,
  output logic [WIDTH-1:0] irq
);
  logic [WIDTH-1:0] prev_q, irq_q, irq_d;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb irq_d[i] = gpio_pkg::edge_hit(pol_rise[i], level[i], prev_q[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '1;
      irq_q  <= '0;
    end else begin
      prev_q <= level;
      irq_q  <= irq_d;
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/gpio_pull_port.sv
module gpio_pull_port #(
  parameter int                WIDTH     = 8,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h00,
  parameter logic [ADDR_W-1:0] PULL_ADDR = 8'h08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  drive_low_o,
  output logic [WIDTH-1:0]  pullup_o,
  output logic [WIDTH-1:0]  irq_o
);
  localparam int SYNC_STAGES = 2;

  logic             rst_sync_n;
  logic [WIDTH-1:0] out_q, pull_q, pin_lvl;

  gpio_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  gpio_regs #(
    .WIDTH(WIDTH), .ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR), .PULL_ADDR(PULL_ADDR)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .out_q     (out_q),
    .pull_q    (pull_q)
  );

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (pin_in),
    .q     (pin_lvl)
  );

  gpio_edge #(.WIDTH(WIDTH)) u_edge (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .level    (pin_lvl),
    .pol_rise (pull_q),
    .irq      (irq_o)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_pad
    gpio_pkg::pad_mode_e mode;
    always_comb begin
      mode           = gpio_pkg::pad_mode(out_q[i], pull_q[i]);
      drive_low_o[i] = (mode == gpio_pkg::PAD_SINK);
      pullup_o[i]    = (mode == gpio_pkg::PAD_PULLUP);
    end
  end

  always_comb bus_rdata = (bus_addr == DATA_ADDR) ? pin_lvl : '0;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int                WIDTH     = 8,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h00,
  parameter logic [ADDR_W-1:0] PULL_ADDR = 8'h08
) (
  input logic              clk,
  input logic              rst_s,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [WIDTH-1:0]  bus_wdata,
  input logic [WIDTH-1:0]  bus_rdata,
  input logic [WIDTH-1:0]  pin_in,
  input logic [WIDTH-1:0]  pull_q,
  input logic [WIDTH-1:0]  drive_low_o,
  input logic [WIDTH-1:0]  pullup_o,
  input logic [WIDTH-1:0]  irq_o
);
  logic [2:0] age_q;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)             age_q <= '0;
    else if (age_q != 3'd7) age_q <= age_q + 3'd1;
  end

  // R3: a pin is never sunk and pulled up at once
  p_sink_excl_r3: assert property (@(posedge clk) disable iff (!rst_s)
    (drive_low_o & pullup_o) == '0);

  p_data_wr_r2: assert property (@(posedge clk) disable iff (!rst_s)
    (bus_wr && bus_addr == DATA_ADDR) |=> drive_low_o == ~$past(bus_wdata));

  p_pull_wr_r4: assert property (@(posedge clk) disable iff (!rst_s)
    (bus_wr && bus_addr == PULL_ADDR) |=>
      pullup_o == (~drive_low_o & ~$past(bus_wdata)));

  // R5 and R8: only the data address returns anything
  p_rd_zero_r5: assert property (@(posedge clk) disable iff (!rst_s)
    (bus_addr != DATA_ADDR) |-> bus_rdata == '0);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_s)
    !bus_wr |=> $stable(drive_low_o) && $stable(pullup_o));

  p_irq_edge_r7: assert property (@(posedge clk) disable iff (!rst_s)
    (age_q >= 3'd6) |->
      irq_o == (( $past(pull_q) &  $past(pin_in, 3) & ~$past(pin_in, 4)) |
                (~$past(pull_q) & ~$past(pin_in, 3) &  $past(pin_in, 4))));

  p_no_irq_steady_r9: assert property (@(posedge clk) disable iff (!rst_s)
    (age_q >= 3'd6 && $past(pin_in, 3) == $past(pin_in, 4)) |-> irq_o == '0);
endmodule

bind gpio_pull_port gpio_port_chk #(
  .WIDTH(WIDTH), .ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR), .PULL_ADDR(PULL_ADDR)
) u_chk (
  .clk         (clk),
  .rst_s       (rst_sync_n),
  .bus_addr    (bus_addr),
  .bus_wr      (bus_wr),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .pin_in      (pin_in),
  .pull_q      (pull_q),
  .drive_low_o (drive_low_o),
  .pullup_o    (pullup_o),
  .irq_o       (irq_o)
);

// File: tb/tb_gpio_pull_port.sv
module tb_gpio_pull_port;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] bus_addr, bus_wdata, pin_in;
  logic       bus_wr;
  logic [7:0] bus_rdata, drive_low_o, pullup_o, irq_o;
  int         n_tests = 0;
  int         n_fail  = 0;

  always #10 clk = ~clk;

  gpio_pull_port dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .drive_low_o(drive_low_o), .pullup_o(pullup_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    step(1);
    bus_wr = 1'b0; bus_addr = 8'h00;
  endtask

  // Pin change, then irq expected only after the third edge.
  task automatic edge_chk(input string req, input logic [7:0] new_pins, input logic [7:0] exp);
    pin_in = new_pins;
    step(1); chk(req, irq_o, 8'h00);
    step(1); chk(req, irq_o, 8'h00);
    step(1); chk(req, irq_o, exp);
    step(1); chk(req, irq_o, 8'h00);
  endtask

  initial begin
    #(200000 * 20);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] pats [4];
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'h55; pats[3] = 8'hA3;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 8'h00; bus_wdata = 8'h00; pin_in = 8'hFF;
    step(3); rst_n = 1'b1; step(5);

    // R1 reset state
    chk("R1 drive", drive_low_o, 8'h00);
    chk("R1 pullup", pullup_o, 8'hFF);
    chk("R1 irq", irq_o, 8'h00);

    // R6 read path latency, and first R7 falling-edge pulse
    chk("R6", bus_rdata, 8'hFF);
    pin_in = 8'h5A;
    step(1); chk("R6 one edge", bus_rdata, 8'hFF);
    step(1); chk("R6 two edges", bus_rdata, 8'h5A);
    step(1); chk("R7 fall", irq_o, 8'hA5);
    step(1); chk("R7 single", irq_o, 8'h00);
    pin_in = 8'hFF; step(4);

    // R2, R3: sweep output register against pull patterns
    for (int p = 0; p < 4; p++) begin
      wr(8'h08, pats[p]);
      for (int d = 0; d < 256; d++) begin
        wr(8'h00, d[7:0]);
        chk("R2", drive_low_o, ~d[7:0]);
        chk("R3", pullup_o, d[7:0] & ~pats[p]);
      end
    end
    // R3, R4: sweep pull register with a mixed output value
    wr(8'h00, 8'hAA);
    for (int p = 0; p < 256; p++) begin
      wr(8'h08, p[7:0]);
      chk("R3 pull sweep", pullup_o, 8'hAA & ~p[7:0]);
      chk("R4 pull sweep", drive_low_o, 8'h55);
    end
    wr(8'h00, 8'hFF); wr(8'h08, 8'hFF);
    chk("R4 float drive", drive_low_o, 8'h00);
    chk("R4 float pull", pullup_o, 8'h00);

    // R5 write-only pull register
    bus_addr = 8'h08; step(1);
    chk("R5", bus_rdata, 8'h00);
    bus_addr = 8'h00;

    // R8 ignored writes and reads
    wr(8'h00, 8'h3C); wr(8'h08, 8'h0F);
    wr(8'h03, 8'h00); wr(8'h09, 8'hF0); wr(8'h01, 8'h00); wr(8'h80, 8'hFF);
    chk("R8 drive", drive_low_o, 8'hC3);
    chk("R8 pullup", pullup_o, 8'h30);
    bus_addr = 8'h00; bus_wdata = 8'h00; bus_wr = 1'b0; step(2);
    chk("R8 no strobe", drive_low_o, 8'hC3);
    bus_addr = 8'h03; step(1);
    chk("R8 read", bus_rdata, 8'h00);
    bus_addr = 8'h00;

    // R7, R9: every pin, both polarities
    wr(8'h00, 8'hFF);
    for (int pol = 0; pol < 2; pol++) begin
      wr(8'h08, pol == 1 ? 8'hFF : 8'h00);
      pin_in = 8'hFF; step(4);
      for (int i = 0; i < 8; i++) begin
        logic [7:0] b;
        b = 8'h01 << i;
        edge_chk(pol == 1 ? "R9 fall ignored" : "R7 fall", ~b, pol == 1 ? 8'h00 : b);
        edge_chk(pol == 1 ? "R7 rise" : "R9 rise ignored", 8'hFF, pol == 1 ? b : 8'h00);
      end
    end

    // R7 mixed polarity, all pins together
    wr(8'h08, 8'h0F);
    edge_chk("R7 mixed fall", 8'h00, 8'hF0);
    edge_chk("R7 mixed rise", 8'hFF, 8'h0F);

    // R9 steady pins
    for (int k = 0; k < 10; k++) begin
      step(1); chk("R9 steady", irq_o, 8'h00);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule